// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator as two 32-bit halves, a high word and a low word. Each accepted operation multiplies two signed operands and adds the product into the accumulator. The long form uses the full 32-bit operands. The word form uses only the low 16 bits of each operand, read as signed values.

A saturation enable changes how each form treats a result that leaves its range. In the long form the result is confined to about 48 bits by forcing the upper bits of the high word. In the word form the result is clamped to a signed 32-bit range, and the high word is set to 1 to mark the clamp. With saturation off, both forms keep the full wrapped 64-bit sum.

Software-style access to the halves comes through a clear strobe and two load strobes. The result and a one-cycle done pulse appear on the clock edge after the start strobe.

Top module: `sat_mac`

## Requirements
- R1: After reset both accumulator halves read zero and `done_o` is low.
- R2: With `op_i`=0 (long form) and `sat_i`=0, the accumulator becomes {hi,lo} + sext64(a_i)*sext64(b_i), wrapped to 64 bits.
- R3: With `op_i`=1 (word form) and `sat_i`=0, the accumulator becomes {hi,lo} + sext64(a_i[15:0])*sext64(b_i[15:0]), wrapped to 64 bits. Operand bits 31:16 have no effect.
- R4: Long form, `sat_i`=1, negative 64-bit sum: high-word bits 31:16 are forced to ones. All other bits keep the sum.
- R5: Long form, `sat_i`=1, non-negative sum: high-word bits 31:15 are forced to zero. All other bits keep the sum.
- R6: Word form, `sat_i`=1, sum below -2^31: the high word becomes 1 and the low word becomes 0x80000000.
- R7: Word form, `sat_i`=1, sum above 2^31-1: the high word becomes 1 and the low word becomes 0x7FFFFFFF.
- R8: Word form, `sat_i`=1, sum within the signed 32-bit range: the full 64-bit sum is kept.
- R9: The result is visible after the first rising edge that samples an accepted `start_i`. `done_o` is high for exactly that one cycle.
- R10: `clr_i` zeroes both halves. It wins over the load strobes and over a start in the same cycle, and that start gives no `done_o`.
- R11: `ld_hi_i` / `ld_lo_i` write `ld_data_i` into the high / low half. The other half is untouched. Any load in the same cycle as `start_i` drops the operation, and no `done_o` follows.
- R12: With no start, clear or load, both halves hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one multiply-accumulate |
| op_i | input | 1 | 0 = long form, 1 = word form |
| sat_i | input | 1 | Saturation enable |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| clr_i | input | 1 | Zero both halves |
| ld_hi_i | input | 1 | Load high half |
| ld_lo_i | input | 1 | Load low half |
| ld_data_i | input | 32 | Load data |
| acc_hi_o | output | 32 | Accumulator high word |
| acc_lo_o | output | 32 | Accumulator low word |
| done_o | output | 1 | Result-valid pulse |

## Verification
The following are checked on every cycle: the priority of clear over everything else, direct loads of the high half, the done pulse following only accepted starts, the accumulator holding while idle, and the long-form saturation window (upper high-word bits all ones or all zeros). The actual arithmetic can only be shown by the directed scenarios, which compare against a model in the bench. These include the wrapped products of both forms, the word-form clamps with their high-word marker in both directions, and the in-range case that keeps the full sum.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/sat_mac_mul.sv
module sat_mac_mul
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  mac_op_e                  op_i,
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  output logic signed [ACC_W-1:0]  prod_o
);
  logic [DATA_W-1:0]       a_sel, b_sel;
  logic signed [ACC_W-1:0] a_ext, b_ext;

  always_comb begin
    if (op_i == OP_WORD) begin
      a_sel = {{(DATA_W-WORD_W){a_i[WORD_W-1]}}, a_i[WORD_W-1:0]};
      b_sel = {{(DATA_W-WORD_W){b_i[WORD_W-1]}}, b_i[WORD_W-1:0]};
    end else begin
      a_sel = a_i;
      b_sel = b_i;
    end
    a_ext  = {{DATA_W{a_sel[DATA_W-1]}}, a_sel};
    b_ext  = {{DATA_W{b_sel[DATA_W-1]}}, b_sel};
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/sat_mac_sat.sv
module sat_mac_sat
  import sat_mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SAT_LSB = 15,
  localparam int ACC_W = 2 * DATA_W
) (
  input  mac_op_e            op_i,
  input  logic               sat_i,
  input  logic [ACC_W-1:0]   sum_i,
  output logic [DATA_W-1:0]  hi_o,
  output logic [DATA_W-1:0]  lo_o
);
  // long form: negative forces bits above SAT_LSB, non-negative clears from SAT_LSB up
  localparam logic [DATA_W-1:0] NEG_SET  = ~((DATA_W'(1) << (SAT_LSB + 1)) - DATA_W'(1));
  localparam logic [DATA_W-1:0] POS_KEEP = (DATA_W'(1) << SAT_LSB) - DATA_W'(1);
  localparam int UPPER_W = ACC_W - DATA_W + 1;

  logic [UPPER_W-1:0] upper;
  logic               neg, under, over;

  always_comb begin
    upper = sum_i[ACC_W-1:DATA_W-1];
    neg   = sum_i[ACC_W-1];
    under = neg && !(&upper);
    over  = !neg && (|upper);
    hi_o  = sum_i[ACC_W-1:DATA_W];
    lo_o  = sum_i[DATA_W-1:0];
    if (sat_i) begin
      if (op_i == OP_LONG) begin
        hi_o = neg ? (hi_o | NEG_SET) : (hi_o & POS_KEEP);
      end else if (under) begin
        hi_o = DATA_W'(1);
        lo_o = {1'b1, {(DATA_W-1){1'b0}}};
      end else if (over) begin
        hi_o = DATA_W'(1);
        lo_o = {1'b0, {(DATA_W-1){1'b1}}};
      end
    end
  end
endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 16,
  parameter int SAT_LSB = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic              sat_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              clr_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic              done_o
);
  localparam int ACC_W = 2 * DATA_W;

  mac_op_e                 op;
  logic signed [ACC_W-1:0] prod;
  logic [ACC_W-1:0]        sum;
  logic [DATA_W-1:0]       nxt_hi, nxt_lo;
  logic [DATA_W-1:0]       hi_q, lo_q;
  logic                    done_q, ld_any, mac_go;

  assign op     = mac_op_e'(op_i);
  assign ld_any = ld_hi_i | ld_lo_i;
  assign mac_go = start_i & ~clr_i & ~ld_any;

  sat_mac_mul #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_mul (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .prod_o(prod)
  );

  assign sum = {hi_q, lo_q} + prod;

  sat_mac_sat #(.DATA_W(DATA_W), .SAT_LSB(SAT_LSB)) u_sat (
    .op_i (op),
    .sat_i(sat_i),
    .sum_i(sum),
    .hi_o (nxt_hi),
    .lo_o (nxt_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= mac_go;
      if (clr_i) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (ld_any) begin
        if (ld_hi_i) hi_q <= ld_data_i;
        if (ld_lo_i) lo_q <= ld_data_i;
      end else if (start_i) begin
        hi_q <= nxt_hi;
        lo_q <= nxt_lo;
      end
    end
  end

  assign acc_hi_o = hi_q;
  assign acc_lo_o = lo_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk #(
  parameter int DATA_W  = 32,
  parameter int SAT_LSB = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              op_i,
  input logic              sat_i,
  input logic              clr_i,
  input logic              ld_hi_i,
  input logic              ld_lo_i,
  input logic [DATA_W-1:0] ld_data_i,
  input logic [DATA_W-1:0] acc_hi_o,
  input logic [DATA_W-1:0] acc_lo_o,
  input logic              done_o
);
  logic go, idle;
  assign go   = start_i && !clr_i && !ld_hi_i && !ld_lo_i;
  assign idle = !start_i && !clr_i && !ld_hi_i && !ld_lo_i;

  a_r10_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_hi_o == '0) && (acc_lo_o == '0) && !done_o);

  a_r11_load_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_hi_i) |=> acc_hi_o == $past(ld_data_i));

  a_r9_done_after_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> done_o);

  a_r9_no_stray_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |=> !done_o);

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(acc_hi_o) && $stable(acc_lo_o));

  // R4 and R5: saturated long form leaves upper high-word bits all ones or all zeros
  a_r5_long_sat_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !op_i && sat_i) |=>
      (&acc_hi_o[DATA_W-1:SAT_LSB+1]) || (acc_hi_o[DATA_W-1:SAT_LSB] == '0));
endmodule

bind sat_mac sat_mac_chk #(.DATA_W(DATA_W), .SAT_LSB(SAT_LSB)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .sat_i    (sat_i),
  .clr_i    (clr_i),
  .ld_hi_i  (ld_hi_i),
  .ld_lo_i  (ld_lo_i),
  .ld_data_i(ld_data_i),
  .acc_hi_o (acc_hi_o),
  .acc_lo_o (acc_lo_o),
  .done_o   (done_o)
);

// File: tb/sat_mac_tb.sv
module sat_mac_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, op_i = 1'b0, sat_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, ld_data_i = '0;
  logic        clr_i = 1'b0, ld_hi_i = 1'b0, ld_lo_i = 1'b0;
  logic [31:0] acc_hi_o, acc_lo_o;
  logic        done_o;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;
  logic [63:0] exp_acc = '0;

  always #4 clk_i = ~clk_i;

  sat_mac u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .sat_i(sat_i),
    .a_i(a_i), .b_i(b_i), .clr_i(clr_i), .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i),
    .ld_data_i(ld_data_i), .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .done_o(done_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_acc(string req);
    chk({req, " hi"}, acc_hi_o, exp_acc[63:32]);
    chk({req, " lo"}, acc_lo_o, exp_acc[31:0]);
  endtask

  function automatic logic [63:0] model(logic [63:0] acc, bit op, bit sat,
                                        logic [31:0] a, logic [31:0] b);
    longint pa, pb, s;
    logic [63:0] r;
    if (op) begin
      pa = longint'($signed(a[15:0]));
      pb = longint'($signed(b[15:0]));
    end else begin
      pa = longint'($signed(a));
      pb = longint'($signed(b));
    end
    s = longint'(acc) + pa * pb;
    r = s;
    if (sat && !op) begin
      if (s < 0) r[63:48] = 16'hFFFF;
      else       r[63:47] = '0;
    end else if (sat && op) begin
      if (s < -64'sd2147483648)     r = 64'h1_8000_0000;
      else if (s > 64'sd2147483647) r = 64'h1_7FFF_FFFF;
    end
    return r;
  endfunction

  task automatic load(logic [31:0] hi, logic [31:0] lo);
    @(negedge clk_i);
    ld_hi_i = 1; ld_data_i = hi;
    @(negedge clk_i);
    ld_hi_i = 0; ld_lo_i = 1; ld_data_i = lo;
    @(negedge clk_i);
    ld_lo_i = 0;
    exp_acc = {hi, lo};
  endtask

  task automatic mac(string req, bit op, bit sat, logic [31:0] a, logic [31:0] b);
    @(negedge clk_i);
    start_i = 1; op_i = op; sat_i = sat; a_i = a; b_i = b;
    exp_acc = model(exp_acc, op, sat, a, b);
    @(negedge clk_i);
    start_i = 0;
    chk_acc(req);
    chk({req, " R9 done"}, {31'b0, done_o}, 32'd1);
    @(negedge clk_i);
    chk({req, " R9 done single"}, {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 hi", acc_hi_o, 0);
    chk("R1 lo", acc_lo_o, 0);
    chk("R1 done", {31'b0, done_o}, 0);
  endtask

  task automatic t_long_plain();
    load(32'h0, 32'd5);
    mac("R2 neg", 0, 0, 32'hFFFF_FFFD, 32'd7);
    mac("R2 big", 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    mac("R2 wrap", 0, 0, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_word_plain();
    load(32'h0, 32'h0);
    mac("R3 upper ignored", 1, 0, 32'hFFFF_8000, 32'h1234_8000);
    mac("R3 negative", 1, 0, 32'hABCD_FFFF, 32'h0000_0003);
  endtask

  task automatic t_long_sat();
    load(32'h0, 32'h0);
    mac("R4", 0, 1, 32'h8000_0000, 32'h7FFF_FFFF);
    load(32'h0, 32'h0);
    mac("R5", 0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    chk("R5 hi value", acc_hi_o, 32'h0000_7FFF);
  endtask

  task automatic t_word_sat();
    load(32'h0, 32'h7FFF_FFF0);
    mac("R7", 1, 1, 32'h10, 32'h10);
    chk("R7 marker", acc_hi_o, 32'd1);
    load(32'hFFFF_FFFF, 32'h8000_0000);
    mac("R6", 1, 1, 32'hFFFF, 32'h1);
    chk("R6 clamp", acc_lo_o, 32'h8000_0000);
    load(32'hFFFF_FFFF, 32'hFFFF_FF00);
    mac("R8", 1, 1, 32'h20, 32'h4);
  endtask

  task automatic t_priority();
    load(32'h1234_5678, 32'h9ABC_DEF0);
    @(negedge clk_i);
    clr_i = 1; ld_hi_i = 1; ld_data_i = 32'hDEAD_BEEF; start_i = 1;
    a_i = 32'd3; b_i = 32'd3; op_i = 0; sat_i = 0;
    @(negedge clk_i);
    clr_i = 0; ld_hi_i = 0; start_i = 0;
    exp_acc = '0;
    chk_acc("R10 clear wins");
    chk("R10 no done", {31'b0, done_o}, 0);
    load(32'h0000_0011, 32'h0000_0022);
    @(negedge clk_i);
    ld_hi_i = 1; ld_data_i = 32'h5555_AAAA; start_i = 1; a_i = 32'd9; b_i = 32'd9;
    @(negedge clk_i);
    ld_hi_i = 0; start_i = 0;
    exp_acc[63:32] = 32'h5555_AAAA;
    chk_acc("R11 load beats mac");
    chk("R11 no done", {31'b0, done_o}, 0);
  endtask

  task automatic t_hold();
    @(negedge clk_i);
    a_i = 32'hFFFF_FFFF; b_i = 32'h1234; op_i = 1; sat_i = 1;
    repeat (3) @(negedge clk_i);
    chk_acc("R12 hold");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_long_plain();
    t_word_plain();
    t_long_sat();
    t_word_sat();
    t_priority();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule